// File: doc/BRIEF.md
# General-Purpose I/O Port with Serial Transmit Override

This block is an 8-bit general-purpose I/O port driven from a small synchronous register bus. A direction register chooses, pin by pin, whether the pad output buffer is enabled. A data latch holds the value that driven pins put out. Reading the data register returns a mix: a pin set as an output returns its latch bit, and a pin set as an input returns its pad level after a two-flop synchronizer.

An on-chip serial transmitter can take over pin 0. While its enable input is high, pin 0 drives the transmitter's data and its output buffer is on, whatever its direction bit says. The direction bit still chooses the read-back source for pin 0 during this time. Software can load the data latch while pins are still inputs. Turning a pin into an output afterwards then puts out the loaded value from the first cycle, with no glitch.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register reads 0x00 at offset 0x0C, the data latch is 0x00, and with the serial enable low every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: A bus write with `bus_wr` high at offset 0x0C loads the direction register on that clock edge. It reads back unchanged at 0x0C, and each non-overridden `pad_oe` bit equals its direction bit (1 = output, 0 = input).
- R3: A bus write at offset 0x08 loads the data latch on that clock edge, whatever the direction bits are. Non-overridden `pad_out` bits show the latch, so a value loaded while a pin is an input appears at the pad in the same cycle that its direction bit becomes 1.
- R4: Reading offset 0x08 returns, for each bit whose direction bit is 1, the data latch bit.
- R5: Reading offset 0x08 returns, for each bit whose direction bit is 0, the `pad_in` level sampled two rising edges earlier. A pad change is not visible after only one edge.
- R6: While `ser_en` is 1, `pad_oe[0]` is 1 and `pad_out[0]` follows `ser_txd` whatever direction bit 0 holds. Pins 1 to 7 are unaffected.
- R7: While `ser_en` is 1, bit 0 of a read at 0x08 is still chosen by direction bit 0: the latch when it is 1, the synchronized pad when it is 0.
- R8: While `ser_en` is 0, pin 0 behaves like the other pins: `pad_oe[0]` equals direction bit 0 and `pad_out[0]` equals latch bit 0.
- R9: A read at any offset other than 0x08 and 0x0C returns 0x00. A write there changes neither the direction register nor the data latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = driving |
| ser_en | input | 1 | Serial transmitter enable, takes over pin 0 |
| ser_txd | input | 1 | Serial transmit data for pin 0 |

## Verification
The override and the read-back path meet on pin 0. While `ser_en` holds the pad, a data-latch write and a direction change can land in the same cycles. The bench raises `ser_en` with direction bit 0 clear, drives `pad_in[0]` against `ser_txd`, and writes the latch and then the direction register. At each step it checks that `pad_out[0]` keeps following the transmitter. It also checks that bit 0 of the data read moves from the synchronized pad to the latch only when direction bit 0 becomes 1.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned GPIO_W   = 8;
  localparam int unsigned GPIO_AW  = 8;
  localparam int unsigned OFF_DIR  = 'h0C;
  localparam int unsigned OFF_DATA = 'h08;
  localparam int unsigned SYNC_N   = 2;
  localparam int unsigned OVR_PIN  = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[k] <= '0;
          else        stg_q[k] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[k] <= '0;
          else        stg_q[k] <= stg_q[k-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

  // Age counter used only to qualify the latency assertion
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R5
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned AW       = 8,
  parameter int unsigned DIR_OFF  = 'h0C,
  parameter int unsigned DATA_OFF = 'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  lat_q
);
  localparam logic [AW-1:0] A_DIR  = AW'(DIR_OFF);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_OFF);

  function automatic rd_sel_e decode(input logic [AW-1:0] a);
    if (a == A_DIR)       return SEL_DIR;
    else if (a == A_DATA) return SEL_DATA;
    else                  return SEL_NONE;
  endfunction

  // Per-bit choice: driven pins read their latch, others the synchronized pad
  function automatic logic [W-1:0] mix_back(input logic [W-1:0] dir,
                                            input logic [W-1:0] lat,
                                            input logic [W-1:0] pin);
    return (dir & lat) | (~dir & pin);
  endfunction

  rd_sel_e sel;
  logic    wr_dir, wr_dat, wr_miss;

  assign sel     = decode(bus_addr);
  assign wr_dir  = bus_wr && (sel == SEL_DIR);
  assign wr_dat  = bus_wr && (sel == SEL_DATA);
  assign wr_miss = bus_wr && (sel == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (wr_dat) lat_q <= bus_wdata;
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:  bus_rdata = dir_q;
      SEL_DATA: bus_rdata = mix_back(dir_q, lat_q, pin_sync);
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(bus_wdata)));

  // R3
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (lat_q == $past(bus_wdata)));

  // R9
  miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> ($stable(dir_q) && $stable(lat_q)));

  // R9
  miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));

  // R4
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |-> (((bus_rdata ^ lat_q) & dir_q) == '0));
endmodule

// File: rtl/gpio_padmux.sv
`timescale 1ns/1ps
module gpio_padmux #(
  parameter int unsigned W   = 8,
  parameter int unsigned OVR = 0
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic         ser_en,
  input  logic         ser_txd,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      if (i == OVR) begin : g_ovr
        assign pad_oe[i]  = ser_en ? 1'b1    : dir_q[i];
        assign pad_out[i] = ser_en ? ser_txd : lat_q[i];
      end else begin : g_plain
        assign pad_oe[i]  = dir_q[i];
        assign pad_out[i] = lat_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ovr.sv
`timescale 1ns/1ps
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int unsigned W        = GPIO_W,
  parameter int unsigned AW       = GPIO_AW,
  parameter int unsigned DIR_OFF  = OFF_DIR,
  parameter int unsigned DATA_OFF = OFF_DATA,
  parameter int unsigned STAGES   = SYNC_N,
  parameter int unsigned OVR      = OVR_PIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic          ser_en,
  input  logic          ser_txd
);
  localparam logic [W-1:0] OVR_MASK = W'(1) << OVR;

  logic [W-1:0] pin_sync, dir_q, lat_q;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync));

  gpio_regs #(.W(W), .AW(AW), .DIR_OFF(DIR_OFF), .DATA_OFF(DATA_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
    .dir_q(dir_q), .lat_q(lat_q));

  gpio_padmux #(.W(W), .OVR(OVR)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .ser_en(ser_en), .ser_txd(ser_txd),
    .pad_out(pad_out), .pad_oe(pad_oe));

  // R6
  ovr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pad_oe[OVR] && (pad_out[OVR] == ser_txd)));

  // R6
  ovr_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (((pad_oe ^ dir_q) & ~OVR_MASK) == '0));

  // R8
  gpio_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> ((pad_oe == dir_q) && (pad_out == lat_q)));
endmodule

// File: tb/test_gpio_port_ovr.sv
`timescale 1ns/1ps
module test_gpio_port_ovr;
  localparam logic [7:0] A_DIR  = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h08;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, pad_in = 8'h00;
  logic       bus_wr = 1'b0, ser_en = 1'b0, ser_txd = 1'b0;
  logic [7:0] bus_rdata, pad_out, pad_oe;

  int checks = 0, fails = 0;

  gpio_port_ovr i_gpio_port_ovr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ser_en(ser_en), .ser_txd(ser_txd));

  always #5 clk = ~clk;

  // Each entry: {direction, latch, pad}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'h5A, 8'h00},
    {8'h00, 8'hFF, 8'hC3},
    {8'hF0, 8'h3C, 8'hA5},
    {8'h0F, 8'h96, 8'h69},
    {8'hAA, 8'h00, 8'hFF},
    {8'h55, 8'hFF, 8'h00}
  };

  function automatic logic [7:0] expect_rd(input logic [7:0] d, l, p);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = d[b] ? l[b] : p[b];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_DIR, v);  chk("R1 dir", v, 8'h00);
    rd(A_DATA, v); chk("R1 data", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);

    // Vector table: R2, R4, R5
    for (int n = 0; n < NV; n++) begin
      wr(A_DIR, VEC[n][23:16]);
      wr(A_DATA, VEC[n][15:8]);
      pad_in = VEC[n][7:0];
      repeat (2) @(negedge clk);
      rd(A_DIR, v);  chk("R2 dir readback", v, VEC[n][23:16]);
      chk("R2 oe", pad_oe, VEC[n][23:16]);
      chk("R3 out", pad_out, VEC[n][15:8]);
      rd(A_DATA, v); chk("R4/R5 data mix", v,
                         expect_rd(VEC[n][23:16], VEC[n][15:8], VEC[n][7:0]));
    end

    // R5 two-edge latency
    wr(A_DIR, 8'h00);
    pad_in = 8'h00;
    repeat (2) @(negedge clk);
    pad_in = 8'h7E;
    @(negedge clk);
    rd(A_DATA, v); chk("R5 one edge", v, 8'h00);
    @(negedge clk);
    rd(A_DATA, v); chk("R5 two edges", v, 8'h7E);

    // R3 preload while input, then switch to output
    wr(A_DATA, 8'hA5);
    chk("R3 oe still off", pad_oe, 8'h00);
    @(negedge clk);
    bus_addr = A_DIR; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(posedge clk); #1;
    chk("R3 out at switch", pad_out, 8'hA5);
    chk("R3 oe at switch", pad_oe, 8'hFF);
    @(negedge clk); bus_wr = 1'b0;

    // R6/R7 override with direction bit 0 clear
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h00);
    pad_in = 8'h01;
    ser_en = 1'b1; ser_txd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 oe", pad_oe, 8'h01);
    chk("R6 out low", pad_out, 8'h00);
    ser_txd = 1'b1; #1;
    chk("R6 out high", pad_out, 8'h01);
    rd(A_DATA, v); chk("R7 pin read", v & 8'h01, 8'h01);
    wr(A_DATA, 8'hFE);
    ser_txd = 1'b0; #1;
    chk("R6 out follows txd", pad_out, 8'hFE);
    wr(A_DIR, 8'h01);
    rd(A_DATA, v); chk("R7 latch read", v & 8'h01, 8'h00);
    chk("R6 oe with dir", pad_oe, 8'h01);
    ser_txd = 1'b1; #1;
    chk("R6 txd over latch", pad_out, 8'hFF);

    // R8 release
    ser_en = 1'b0;
    wr(A_DIR, 8'h00);
    chk("R8 oe", pad_oe, 8'h00);
    chk("R8 out", pad_out, 8'hFE);
    wr(A_DIR, 8'h01);
    chk("R8 oe set", pad_oe, 8'h01);

    // R9 unmapped
    wr(A_DATA, 8'h3C);
    wr(A_DIR, 8'hF0);
    wr(8'h05, 8'hFF);
    wr(8'hFF, 8'h00);
    rd(8'h05, v);  chk("R9 read zero", v, 8'h00);
    rd(A_DIR, v);  chk("R9 dir kept", v, 8'hF0);
    chk("R9 latch kept", pad_out, 8'h3C);

    finish_run();
  end
endmodule